// File: doc/BRIEF.md
# Streaming Binary Erosion and Dilation with Rectangular Windows

This block applies binary erosion or dilation with a flat, all-ones rectangular structuring element to an image that arrives one pixel per clock in raster order. No delay lines of pixels are kept. The block counts consecutive ones along the current row. It also keeps, for every image column, a saturating count of consecutive rows in which that row-run reached the element width. The column memory is read once and written once per pixel, whatever the element size. Each word is only as wide as needed to count up to the largest element height.

Width and height of the element are run-time inputs, from 1 up to `SE_MAX`. A mode input selects dilation, which is formed as the complement of the erosion of the complemented image. The row length is the parameter `IMG_W`. A start-of-frame flag on the first pixel restarts the raster. The output stream mirrors the input stream one clock later and never stalls. Each result is anchored at the bottom-right corner of its window.

Top module: `rlmorph_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` and `out_pix` are 0 after that edge.
- R2: `out_valid` equals `in_valid` one clock earlier, and `out_sof` is 1 exactly when the pixel accepted one clock earlier carried `in_sof`. Every valid pixel yields one result, with no stall.
- R3: In erosion mode (`cfg_dilate`=0), a result is 1 exactly when its window lies inside the image and every pixel in the window is 1. The window covers `cfg_se_h` rows by `cfg_se_w` columns and ends at the current pixel, at its bottom-right corner.
- R4: In erosion mode, any pixel whose window reaches past the top or left image edge produces 0.
- R5: In dilation mode (`cfg_dilate`=1), a result is 1 when its window reaches past the top or left edge, or when any pixel in the window is 1. Otherwise it is 0.
- R6: With a 1×1 element, the result equals the input pixel in both modes.
- R7: An element of `SE_MAX`×`SE_MAX` is handled exactly as R3 to R5 describe.
- R8: A valid pixel with `in_sof`=1 is row 0, column 0. Image data from an earlier frame has no influence on any result of the new frame.
- R9: Cycles with `in_valid` low are ignored. Raster position and all run counts resume unchanged with the next valid pixel.
- R10: A row holds `IMG_W` pixels. Horizontal runs never continue from the end of one row into the next row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_se_w | input | $clog2(SE_MAX+1) | Element width, 1..SE_MAX |
| cfg_se_h | input | $clog2(SE_MAX+1) | Element height, 1..SE_MAX |
| cfg_dilate | input | 1 | 0 = erosion, 1 = dilation |
| in_valid | input | 1 | Input pixel present |
| in_sof | input | 1 | First pixel of a frame |
| in_pix | input | 1 | Binary input pixel |
| out_valid | output | 1 | Result present |
| out_sof | output | 1 | Result belongs to the first pixel of a frame |
| out_pix | output | 1 | Eroded or dilated pixel |

## Verification
A wrong row-run count shows up at the ports within the same row. The first window that should open or close does so one or more columns early or late. A corrupted or stale column count does not show until the same column comes round in a later row, so it can stay hidden for up to a full row. Because of this, every result of every frame is compared against a direct window evaluation. Frames are driven back to back, idle gaps are inserted, and both the smallest and the largest element are used. A missed reset of the top-row flag, or a broken row wrap, then corrupts the results near the edges of the following frame.

// File: rtl/rlmorph_pkg.sv
// Shared definitions for the run-length morphology block.
// Assumes nothing beyond IEEE 1800-2017 packages.
package rlmorph_pkg;
    typedef enum logic {
        MODE_ERODE  = 1'b0,
        MODE_DILATE = 1'b1
    } morph_mode_e;
endpackage

// File: rtl/rlm_hrun.sv
// Horizontal run counter: counts consecutive ones along the current row,
// saturating at the element width, and flags when the run reaches it.
// Assumes se_w >= 1 and that row_start is raised on the first pixel of a row.
module rlm_hrun #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          row_start,
    input  logic          bit_in,
    input  logic [CW-1:0] se_w,
    output logic          hit
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] base;
    logic [CW-1:0] nx;

    // next run length for the pixel now presented
    always_comb begin
        base = row_start ? '0 : cnt_q;
        if (!bit_in)
            nx = '0;
        else if (base >= se_w)
            nx = se_w;
        else
            nx = base + 1'b1;
        hit = bit_in && (nx >= se_w);
    end

    // hold the run length between valid pixels
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (en)
            cnt_q <= nx;
    end
endmodule

// File: rtl/rlm_vcol.sv
// Per-column vertical run store: one saturating count per image column of
// consecutive rows whose horizontal run reached the element width.
// One read and one write per pixel. Assumes se_h >= 1. Words are not reset;
// top_row forces the read value to zero on the first row of each frame.
module rlm_vcol #(
    parameter int IMG_W = 640,
    parameter int CW    = 6,
    parameter int XW    = 10
) (
    input  logic          clk,
    input  logic          en,
    input  logic [XW-1:0] col,
    input  logic          top_row,
    input  logic          h_hit,
    input  logic [CW-1:0] se_h,
    output logic          v_hit
);
    logic [CW-1:0] mem [IMG_W];
    logic [CW-1:0] v_old;
    logic [CW-1:0] v_nx;

    // read the column word and form its successor
    always_comb begin
        v_old = top_row ? '0 : mem[col];
        if (!h_hit)
            v_nx = '0;
        else if (v_old >= se_h)
            v_nx = se_h;
        else
            v_nx = v_old + 1'b1;
        v_hit = h_hit && (v_nx >= se_h);
    end

    // write back the updated column word
    always_ff @(posedge clk) begin
        if (en)
            mem[col] <= v_nx;
    end
endmodule

// File: rtl/rlmorph_top.sv
// Streaming binary erosion/dilation with a flat rectangular element.
// One pixel per clock in raster order, result one clock later, no stalls.
// Assumes: in_sof is given with the first valid pixel of each frame, rows are
// IMG_W pixels long, configuration is held stable during a frame and is 1..SE_MAX.
module rlmorph_top
    import rlmorph_pkg::*;
#(
    parameter int IMG_W  = 640,
    parameter int SE_MAX = 63,
    localparam int CW    = $clog2(SE_MAX + 1),
    localparam int XW    = (IMG_W > 1) ? $clog2(IMG_W) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cfg_se_w,
    input  logic [CW-1:0] cfg_se_h,
    input  logic          cfg_dilate,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_pix,
    output logic          out_valid,
    output logic          out_sof,
    output logic          out_pix
);
    morph_mode_e   mode;
    logic [XW-1:0] col_q, col_cur;
    logic          top_q, top_cur;
    logic          last_col;
    logic          pix_e;
    logic          h_hit;
    logic          v_hit;

    // raster position of the pixel now presented
    always_comb begin
        mode     = cfg_dilate ? MODE_DILATE : MODE_ERODE;
        col_cur  = in_sof ? '0 : col_q;
        top_cur  = in_sof ? 1'b1 : top_q;
        last_col = (col_cur == XW'(IMG_W - 1));
        pix_e    = in_pix ^ (mode == MODE_DILATE);
    end

    // advance column and top-row flag on each valid pixel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            top_q <= 1'b1;
        end else if (in_valid) begin
            col_q <= last_col ? '0 : col_cur + 1'b1;
            top_q <= last_col ? 1'b0 : top_cur;
        end
    end

    rlm_hrun #(.CW(CW)) i_hrun (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (in_valid),
        .row_start (col_cur == '0),
        .bit_in    (pix_e),
        .se_w      (cfg_se_w),
        .hit       (h_hit)
    );

    rlm_vcol #(.IMG_W(IMG_W), .CW(CW), .XW(XW)) i_vcol (
        .clk     (clk),
        .en      (in_valid),
        .col     (col_cur),
        .top_row (top_cur),
        .h_hit   (h_hit),
        .se_h    (cfg_se_h),
        .v_hit   (v_hit)
    );

    // register the output stream
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_pix   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_sof   <= in_valid && in_sof;
            out_pix   <= in_valid && (v_hit ^ (mode == MODE_DILATE));
        end
    end
endmodule

// File: rtl/rlmorph_chk.sv
// Port-level properties of rlmorph_top, attached with bind below.
module rlmorph_chk #(
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] cfg_se_w,
    input logic [CW-1:0] cfg_se_h,
    input logic          cfg_dilate,
    input logic          in_valid,
    input logic          in_sof,
    input logic          in_pix,
    input logic          out_valid,
    input logic          out_sof,
    input logic          out_pix
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_pix));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2
    sof_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |=> out_sof);

    // R6
    unit_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_se_w == 1 && cfg_se_h == 1) |=> (out_pix == $past(in_pix)));

    // R3
    zero_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg_dilate && !in_pix) |=> !out_pix);

    // R5
    one_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_dilate && in_pix) |=> out_pix);
endmodule

bind rlmorph_top rlmorph_chk #(.CW(CW)) i_chk (.*);

// File: tb/test_rlmorph_top.sv
`timescale 1ns/1ps
module test_rlmorph_top;
    localparam int COLS = 12;
    localparam int ROWS = 8;
    localparam int SMAX = 7;
    localparam int CW   = $clog2(SMAX + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic [CW-1:0] cfg_se_w, cfg_se_h;
    logic          cfg_dilate;
    logic          in_valid, in_sof, in_pix;
    logic          out_valid, out_sof, out_pix;

    int    checks = 0;
    int    failures = 0;
    bit    done = 0;
    bit    img [ROWS][COLS];
    bit    pend_v, pend_s, pend_e;
    string pend_tag;

    rlmorph_top #(.IMG_W(COLS), .SE_MAX(SMAX)) i_rlmorph_top (.*);

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // window evaluation from R3, R4, R5: window ends at (r,c)
    function automatic bit model(int r, int c, int w, int h, bit dil);
        bit all1 = 1, any1 = 0;
        if (r < h - 1 || c < w - 1) return dil;
        for (int i = r - h + 1; i <= r; i++)
            for (int j = c - w + 1; j <= c; j++) begin
                all1 &= img[i][j];
                any1 |= img[i][j];
            end
        return dil ? any1 : all1;
    endfunction

    // one clock: check the result of the previous cycle, then drive this one
    task automatic step(input bit v, input bit s, input bit p, input bit e, input string tag);
        @(negedge clk);
        chk(pend_v ? "R2 valid" : "R9 idle", int'(out_valid), int'(pend_v));
        if (pend_v) begin
            chk("R2 sof", int'(out_sof), int'(pend_s));
            chk(pend_tag, int'(out_pix), int'(pend_e));
        end
        in_valid = v; in_sof = s; in_pix = p;
        pend_v = v; pend_s = s; pend_e = e; pend_tag = tag;
    endtask

    task automatic frame(input int w, input int h, input bit dil, input int dens, input bit gaps);
        step(0, 0, 0, 0, "");
        cfg_se_w = CW'(w); cfg_se_h = CW'(h); cfg_dilate = dil;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                img[r][c] = ($urandom_range(99) < dens);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                string tag;
                if (dil) tag = "R5";
                else if (r < h - 1) tag = "R4 R8";
                else if (c < w - 1) tag = "R4 R10";
                else if (w == 1 && h == 1) tag = "R6";
                else if (w == SMAX && h == SMAX) tag = "R7";
                else tag = "R3";
                if (gaps && $urandom_range(4) == 0) step(0, 0, 1, 0, "");
                step(1, (r == 0 && c == 0), img[r][c], model(r, c, w, h, dil), tag);
            end
    endtask

    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 0; in_valid = 0; in_sof = 0; in_pix = 0;
        cfg_se_w = 1; cfg_se_h = 1; cfg_dilate = 0;
        pend_v = 0; pend_s = 0; pend_e = 0; pend_tag = "";
        repeat (3) @(negedge clk);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 out_pix", int'(out_pix), 0);
        rst_n = 1;
        for (int m = 0; m < 2; m++) begin
            bit dil = (m == 1);
            int dn  = dil ? 15 : 85;
            frame(1, 1, dil, 50, 0);
            frame(SMAX, SMAX, dil, 100, 0);
            frame(SMAX, SMAX, dil, dil ? 3 : 97, 1);
            frame(3, 2, dil, dn, 1);
            frame(2, 5, dil, dn, 0);
            frame(4, 4, dil, dn, 1);
            frame(1, SMAX, dil, dn, 0);
            frame(SMAX, 1, dil, dn, 1);
        end
        frame(3, 3, 0, 100, 0);
        frame(3, 3, 0, 90, 1);
        step(0, 0, 0, 0, "");
        step(0, 0, 0, 0, "");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule